// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a 16-bit-wide parallel NOR flash, written as a synchronous model. It watches the bus write cycles that the host presents, one per clock in which the write strobe is high. It recognises the unlock sequences that guard every data-altering operation, and it turns each completed sequence into a single-clock operation request. The request carries an operation code, the target address and the data. A separate two-bit mode register tells the read path whether reads return the array, the identification words, the query table or the security-ID space.

Program and erase must be preceded by fixed unlock writes. Any write that breaks a sequence throws the decoder back to array-read mode. While the internal program or erase engine reports busy, writes are dropped, with one exception: the erase-suspend write still passes. A write-protect input fences off the 32 K-word boot block and chip erase. The storage array, operation timing and analog behaviour belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `op_valid` is low and `mode` is 0 (array). Any partly entered sequence is discarded.
- R2: The four writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 and then any address and data produce a program request. It shows `op_kind`=0 with the full address and full data, on the clock after the fourth write.
- R3: The five writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55 arm an erase, and the sixth write selects it. Data 0x30 gives a sector erase (`op_kind`=1, address bits 10:0 cleared). Data 0x50 gives a block erase (`op_kind`=2, address bits 14:0 cleared). Data 0x10 at 0x5555 gives a chip erase (`op_kind`=3, address 0). Erase requests carry data 0.
- R4: Sequence matching looks only at address bits 14:0 and data bits 7:0. Higher bits never change the outcome.
- R5: With no sequence in progress, a write of 0xB0 to any address requests erase suspend (`op_kind`=4), and a write of 0x30 requests erase resume (`op_kind`=5). Both carry address 0 and data 0.
- R6: The writes 0x5555/0xAA, 0x2AAA/0x55 followed by 0x5555 with 0x90, 0x98 or 0x88 set `mode` to 1 (identification), 2 (query) or 3 (security ID) on the next clock.
- R7: A single write of 0xF0 with no sequence in progress, or the three-write sequence ending in 0x5555/0xF0, returns `mode` to 0.
- R8: A write that does not match the next expected step sets `mode` to 0 and clears the sequence, so the next write must be the first unlock write again.
- R9: With `wp_n` low, program, sector-erase and block-erase requests whose address lies in the boot block produce no pulse. In the bottom variant (`BOOT_TOP`=0) the boot block is the range where all address bits above bit 14 are 0; in the top variant those bits are all 1. Chip erase produces no pulse either. The sequence is still consumed.
- R10: While `busy` is high, writes change neither `mode` nor sequence progress and request nothing, except a write with data 0xB0, which requests erase suspend.
- R11: `op_valid` is high for exactly one clock per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Internal program/erase in progress |
| wp_n | input | 1 | Low protects the boot block and blocks chip erase |
| op_valid | output | 1 | One-clock operation request |
| op_kind | output | 3 | 0 program, 1 sector, 2 block, 3 chip, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Target address (aligned for erases) |
| op_data | output | DATA_W | Program data, else 0 |
| mode | output | 2 | 0 array, 1 identification, 2 query, 3 security ID |

## Verification
The bench builds the decoder with ADDR_W=17, DATA_W=16 and BOOT_TOP=0. With that width only address bits 16:15 lie above the matched field, so a quarter of random targets land in the boot block. The protect path is therefore hit often, and the same two bits give steady coverage of the don't-care upper address on unlock writes. Random upper data bytes, random busy and random broken sequences cover the abort path.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDENT = 2'd1,
    MODE_QUERY = 2'd2,
    MODE_SECID = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    OP_PROG = 3'd0,
    OP_SECT = 3'd1,
    OP_BLK  = 3'd2,
    OP_CHIP = 3'd3,
    OP_SUSP = 3'd4,
    OP_RES  = 3'd5
  } op_e;

  localparam logic [14:0] UNLOCK_A   = 15'h5555;
  localparam logic [14:0] UNLOCK_B   = 15'h2AAA;
  localparam int          SECTOR_LSB = 11;
  localparam int          BOOT_LSB   = 15;

  // clear the bits below lsb
  function automatic logic [31:0] align_down(input logic [31:0] a, input int lsb);
    return a & ~((32'd1 << lsb) - 32'd1);
  endfunction

  // boot block: bits above BOOT_LSB all zero (bottom) or all one (top)
  function automatic logic in_boot(input logic [31:0] a, input int aw, input logic top);
    logic [31:0] hi;
    logic [31:0] full;
    hi   = a >> BOOT_LSB;
    full = (32'd1 << (aw - BOOT_LSB)) - 32'd1;
    return top ? (hi == full) : (hi == 32'd0);
  endfunction

endpackage

// File: rtl/flash_seq_tracker.sv
module flash_seq_tracker
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [14:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  input  logic        busy,
  output logic        ev_valid,
  output op_e         ev_kind,
  output logic        ev_mode_wr,
  output mode_e       ev_mode_val
);
  localparam int STEP_W = 3;

  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        pend_q, pend_d;   // [0] program armed, [1] erase armed
  logic              at_a, at_b, abort;

  assign at_a = (cmd_addr == UNLOCK_A);
  assign at_b = (cmd_addr == UNLOCK_B);

  always_comb begin
    step_d      = step_q;
    pend_d      = pend_q;
    ev_valid    = 1'b0;
    ev_kind     = OP_PROG;
    ev_mode_wr  = 1'b0;
    ev_mode_val = MODE_ARRAY;
    abort       = 1'b0;
    if (wr_en && busy) begin
      if (cmd_data == 8'hB0) begin
        ev_valid = 1'b1;
        ev_kind  = OP_SUSP;
      end
    end else if (wr_en) begin
      step_d = '0;
      pend_d = '0;
      case (step_q)
        3'd0: begin
          if (at_a && cmd_data == 8'hAA) step_d = 3'd1;
          else if (cmd_data == 8'hB0) begin ev_valid = 1'b1; ev_kind = OP_SUSP; end
          else if (cmd_data == 8'h30) begin ev_valid = 1'b1; ev_kind = OP_RES; end
          else abort = 1'b1;   // includes the single-write exit
        end
        3'd1: begin
          if (at_b && cmd_data == 8'h55) step_d = 3'd2;
          else abort = 1'b1;
        end
        3'd2: begin
          if (!at_a) abort = 1'b1;
          else begin
            case (cmd_data)
              8'hA0: begin step_d = 3'd3; pend_d = 2'b01; end
              8'h80: begin step_d = 3'd3; pend_d = 2'b10; end
              8'h90: begin ev_mode_wr = 1'b1; ev_mode_val = MODE_IDENT; end
              8'h98: begin ev_mode_wr = 1'b1; ev_mode_val = MODE_QUERY; end
              8'h88: begin ev_mode_wr = 1'b1; ev_mode_val = MODE_SECID; end
              default: abort = 1'b1;   // includes 0xF0 exit
            endcase
          end
        end
        3'd3: begin
          if (pend_q[0]) begin ev_valid = 1'b1; ev_kind = OP_PROG; end
          else if (at_a && cmd_data == 8'hAA) begin step_d = 3'd4; pend_d = pend_q; end
          else abort = 1'b1;
        end
        3'd4: begin
          if (at_b && cmd_data == 8'h55) begin step_d = 3'd5; pend_d = pend_q; end
          else abort = 1'b1;
        end
        3'd5: begin
          if (cmd_data == 8'h30) begin ev_valid = 1'b1; ev_kind = OP_SECT; end
          else if (cmd_data == 8'h50) begin ev_valid = 1'b1; ev_kind = OP_BLK; end
          else if (cmd_data == 8'h10 && at_a) begin ev_valid = 1'b1; ev_kind = OP_CHIP; end
          else abort = 1'b1;
        end
        default: abort = 1'b1;
      endcase
      if (abort) begin
        ev_mode_wr  = 1'b1;
        ev_mode_val = MODE_ARRAY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      pend_q <= '0;
    end else begin
      step_q <= step_d;
      pend_q <= pend_d;
    end
  end

  a_r8_step_range: assert property (@(posedge clk) disable iff (rst) step_q <= 3'd5);
  a_r8_pend_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(pend_q));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(step_q));
  a_r2_armed_step: assert property (@(posedge clk) disable iff (rst)
    (pend_q != 2'b00) |-> (step_q >= 3'd3));

endmodule

// File: rtl/flash_op_gate.sv
module flash_op_gate
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  op_e               ev_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_n,
  output logic              op_valid,
  output op_e               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  logic              blocked;
  logic              tgt_boot;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;

  assign tgt_boot = in_boot(32'(wr_addr), ADDR_W, BOOT_TOP);

  always_comb begin
    blocked  = 1'b0;
    tgt_addr = '0;
    tgt_data = '0;
    case (ev_kind)
      OP_PROG: begin
        tgt_addr = wr_addr;
        tgt_data = wr_data;
        blocked  = !wp_n && tgt_boot;
      end
      OP_SECT: begin
        tgt_addr = ADDR_W'(align_down(32'(wr_addr), SECTOR_LSB));
        blocked  = !wp_n && tgt_boot;
      end
      OP_BLK: begin
        tgt_addr = ADDR_W'(align_down(32'(wr_addr), BOOT_LSB));
        blocked  = !wp_n && tgt_boot;
      end
      OP_CHIP: blocked = !wp_n;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_kind  <= OP_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= ev_valid && !blocked;
      op_kind  <= ev_kind;
      op_addr  <= tgt_addr;
      op_data  <= tgt_data;
    end
  end

  a_r9_no_chip_when_locked: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !$past(wp_n)) |-> (op_kind != OP_CHIP));
  a_r9_no_boot_when_locked: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !$past(wp_n) && op_kind inside {OP_PROG, OP_SECT, OP_BLK})
      |-> !in_boot(32'(op_addr), ADDR_W, BOOT_TOP));
  a_r3_erase_no_data: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind != OP_PROG) |-> (op_data == '0));

endmodule

// File: rtl/flash_mode_reg.sv
module flash_mode_reg
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  set,
  input  mode_e val,
  output mode_e mode
);
  always_ff @(posedge clk) begin
    if (rst)      mode <= MODE_ARRAY;
    else if (set) mode <= val;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              wp_n,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [1:0]        mode
);
  logic  ev_valid;
  op_e   ev_kind;
  logic  ev_mode_wr;
  mode_e ev_mode_val;
  op_e   kind_q;
  mode_e mode_q;

  flash_seq_tracker u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .cmd_addr   (wr_addr[14:0]),
    .cmd_data   (wr_data[7:0]),
    .busy       (busy),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_mode_wr (ev_mode_wr),
    .ev_mode_val(ev_mode_val)
  );

  flash_op_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .ev_valid(ev_valid),
    .ev_kind (ev_kind),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wp_n    (wp_n),
    .op_valid(op_valid),
    .op_kind (kind_q),
    .op_addr (op_addr),
    .op_data (op_data)
  );

  flash_mode_reg u_mode (
    .clk (clk),
    .rst (rst),
    .set (ev_mode_wr),
    .val (ev_mode_val),
    .mode(mode_q)
  );

  assign op_kind = kind_q;
  assign mode    = mode_q;

  a_r10_busy_mode: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode));
  a_r11_kind_legal: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_kind <= 3'd5));
  a_r10_busy_only_suspend: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!op_valid || op_kind == 3'd4));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 17;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          wp_n = 1'b1;
  logic          op_valid;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [1:0]    mode;

  int checks = 0;
  int errors = 0;

  // reference state
  int   m_step = 0;
  bit   m_prog = 0, m_erase = 0;
  int   m_mode = 0;
  bit   e_valid;
  int   e_kind;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;
  string tag;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .BOOT_TOP(1'b0)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .wp_n(wp_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .mode(mode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit boot_hit(input logic [AW-1:0] a);
    return a < AW'(32'h8000);
  endfunction

  task automatic expect_op(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit prot, input string req);
    tag = req;
    if (prot) begin tag = "R9"; return; end
    e_valid = 1; e_kind = k; e_addr = a; e_data = d;
  endtask

  task automatic go_array(input string req);
    m_mode = 0; tag = req;
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit bz, input bit wp);
    logic [14:0] la;
    logic [7:0]  ld;
    int          nxt;
    la = a[14:0];
    ld = d[7:0];
    e_valid = 0; e_kind = 0; e_addr = '0; e_data = '0; tag = "R8";
    if (bz) begin
      tag = "R10";
      if (ld == 8'hB0) expect_op(4, '0, '0, 0, "R10");
      return;
    end
    nxt = 0;
    if (m_step == 0) begin
      if (la == 15'h5555 && ld == 8'hAA) begin nxt = 1; tag = "R4"; end
      else if (ld == 8'hB0) expect_op(4, '0, '0, 0, "R5");
      else if (ld == 8'h30) expect_op(5, '0, '0, 0, "R5");
      else go_array(ld == 8'hF0 ? "R7" : "R8");
    end else if (m_step == 1) begin
      if (la == 15'h2AAA && ld == 8'h55) begin nxt = 2; tag = "R4"; end
      else go_array("R8");
    end else if (m_step == 2) begin
      if (la != 15'h5555) go_array("R8");
      else if (ld == 8'hA0) begin nxt = 3; m_prog = 1; tag = "R2"; end
      else if (ld == 8'h80) begin nxt = 3; m_erase = 1; tag = "R3"; end
      else if (ld == 8'h90) begin m_mode = 1; tag = "R6"; end
      else if (ld == 8'h98) begin m_mode = 2; tag = "R6"; end
      else if (ld == 8'h88) begin m_mode = 3; tag = "R6"; end
      else go_array(ld == 8'hF0 ? "R7" : "R8");
    end else if (m_step == 3 && m_prog) begin
      expect_op(0, a, d, !wp && boot_hit(a), "R2");
    end else if (m_step == 3 || m_step == 4) begin
      if (m_step == 3 && la == 15'h5555 && ld == 8'hAA) nxt = 4;
      else if (m_step == 4 && la == 15'h2AAA && ld == 8'h55) nxt = 5;
      else go_array("R8");
      if (nxt != 0) tag = "R3";
    end else begin
      if (ld == 8'h30) expect_op(1, {a[AW-1:11], 11'd0}, '0, !wp && boot_hit(a), "R3");
      else if (ld == 8'h50) expect_op(2, {a[AW-1:15], 15'd0}, '0, !wp && boot_hit(a), "R3");
      else if (ld == 8'h10 && la == 15'h5555) expect_op(3, '0, '0, !wp, "R3");
      else go_array("R8");
    end
    m_step = nxt;
    if (nxt < 3) begin m_prog = 0; m_erase = 0; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit bz = 0, input bit wp = 1);
    model(a, d, bz, wp);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = bz; wp_n = wp;
    @(posedge clk); #1;
    chk(op_valid == e_valid, tag, "op_valid", op_valid, e_valid);
    if (e_valid && op_valid) begin
      chk(op_kind == 3'(e_kind), tag, "op_kind", op_kind, e_kind);
      chk(op_addr == e_addr, tag, "op_addr", op_addr, e_addr);
      chk(op_data == e_data, tag, "op_data", op_data, e_data);
    end
    chk(mode == 2'(m_mode), tag, "mode", mode, m_mode);
    @(negedge clk);
    wr_en = 0; busy = 0; wp_n = 1;
    @(posedge clk); #1;
    chk(op_valid == 1'b0, "R11", "op_valid after pulse", op_valid, 0);
  endtask

  function automatic logic [AW-1:0] ua(input logic [14:0] low);
    return {2'($urandom), low};
  endfunction

  function automatic logic [DW-1:0] ud(input logic [7:0] low);
    return {8'($urandom), low};
  endfunction

  task automatic unlock3(input logic [7:0] cmd, input bit bz = 0, input bit wp = 1);
    wr(ua(15'h5555), ud(8'hAA), bz, wp);
    wr(ua(15'h2AAA), ud(8'h55), bz, wp);
    wr(ua(15'h5555), ud(cmd), bz, wp);
  endtask

  task automatic erase6(input logic [AW-1:0] a, input logic [7:0] cmd, input bit wp);
    unlock3(8'h80, 0, wp);
    wr(ua(15'h5555), ud(8'hAA), 0, wp);
    wr(ua(15'h2AAA), ud(8'h55), 0, wp);
    wr(a, ud(cmd), 0, wp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(op_valid == 0, "R1", "op_valid in reset", op_valid, 0);
    chk(mode == 0, "R1", "mode in reset", mode, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(op_valid == 0 && mode == 0, "R1", "after reset", {op_valid, mode}, 0);

    // directed corner cases
    unlock3(8'hA0); wr(17'h1_2345, 16'hBEEF);          // R2 program
    erase6(17'h1_4F21, 8'h30, 1);                      // R3 sector
    erase6(17'h1_4F21, 8'h50, 1);                      // R3 block
    erase6(17'h0_5555, 8'h10, 1);                      // R3 chip
    erase6(17'h0_1234, 8'h10, 1);                      // R8 chip wrong addr
    unlock3(8'h90);                                    // R6 ident
    wr(17'h0_0000, 16'h00F0, 1, 1);                    // R10 exit dropped while busy
    wr(17'h1_0000, 16'hFFF0);                          // R7 single exit
    unlock3(8'h98); unlock3(8'hF0);                    // R6 / R7 triple exit
    unlock3(8'h88);                                    // R6 secid
    unlock3(8'hA0, 0, 0); wr(17'h0_7FFF, 16'h1234, 0, 0);  // R9 program boot
    erase6(17'h0_2000, 8'h30, 0);                      // R9 sector boot
    erase6(17'h0_5555, 8'h10, 0);                      // R9 chip locked
    unlock3(8'hA0, 0, 0); wr(17'h0_8000, 16'h4321, 0, 0);  // R9 just above boot
    wr(17'h1_5555, 16'hAAAA); wr(17'h0_1111, 16'h0055); // R8 abort at step 1
    wr(17'h0_2AAA, 16'h0055);                          // R8 must not advance
    wr(17'h1_3333, 16'h12B0);                          // R5 suspend
    wr(17'h0_3333, 16'h5530);                          // R5 resume
    wr(17'h0_3333, 16'h00B0, 1);                       // R10 suspend while busy

    // random mix
    for (int n = 0; n < 600; n++) begin
      int  pick;
      bit  wp;
      logic [AW-1:0] a;
      pick = $urandom_range(0, 9);
      wp   = 1'($urandom);
      a    = AW'($urandom);
      case (pick)
        0: begin unlock3(8'hA0, 0, wp); wr(a, DW'($urandom), 0, wp); end
        1: erase6(a, 8'h30, wp);
        2: erase6(a, 8'h50, wp);
        3: erase6(ua(15'h5555), 8'h10, wp);
        4: unlock3(8'h90 + 8'($urandom_range(0, 1)) * 8'h08);
        5: unlock3(8'h88);
        6: wr(a, ud(8'hF0), $urandom_range(0, 4) == 0);
        7: wr(a, ud($urandom_range(0, 1) ? 8'hB0 : 8'h30), $urandom_range(0, 4) == 0);
        8: wr(a, DW'($urandom), $urandom_range(0, 3) == 0, wp);
        default: begin
          wr(ua(15'h5555), ud(8'hAA));
          wr(a, DW'($urandom), $urandom_range(0, 3) == 0);
          wr(ua(15'h5555), ud(8'h80));
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule